// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block holds the pending-interrupt flags of a small microcontroller in one 16-bit register. Each implemented position latches a single-cycle event pulse from its peripheral. The flag then stays set until the CPU accepts that source. A separate per-source enable register and a global master enable decide whether a latched flag becomes a request to the CPU. A lowest-index priority encoder picks the source to present.

Software reaches both registers over a simple byte-addressable bus. It can use a full 16-bit access or a single-byte access to either half. Writing a one to a flag raises a software interrupt, and writing a zero leaves the flag alone. A flag raised by software is held back from the CPU until one more instruction has retired. The block signals this with a retire strobe. Positions that are reserved, or that have no peripheral in this variant, are tied off by a parameter mask.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset both registers read 0x0000, `irq_req` is 0 and `irq_idx` is 0.
- R2: An event pulse on an implemented position sets its flag on the next clock edge, whatever the values of the enable bit and of `master_en`.
- R3: `irq_req` is 1 only when `master_en` is 1 and at least one flag is 1 with its enable bit also 1 and not held back by R6. `irq_idx` reports a pending source even when `master_en` is 0.
- R4: `irq_idx` gives the lowest index among flags that are set, enabled and not held. It is 0 when there is none.
- R5: A bus write of 1 to an implemented flag sets it. A write of 0 has no effect, and an event arriving in the same cycle as a 0 write still sets the flag.
- R6: A flag set by a software write is not counted as pending until a cycle in which `instr_ret` is 1, and that cycle must come after the write cycle.
- R7: `ack_valid` with `ack_idx` = k clears flag k on the next edge and leaves every other flag unchanged.
- R8: If an event for flag k arrives in the same cycle as an acknowledge of k, flag k stays 1.
- R9: Positions cleared in `IMPL_MASK` ignore events and writes and always read 0 in both registers. The default mask 0x77FF leaves bits 15 and 11 unimplemented.
- R10: `bus_addr[1]` selects the register: 0 selects the flags and 1 selects the enables. A word access (`bus_word`=1) uses all 16 bits and ignores `bus_addr[0]`. A byte access uses `bus_addr[0]` to pick the low (0) or high (1) byte. Its data travels on bits 7:0, it reads with bits 15:8 as 0, and it leaves the other byte untouched. A write to the enables replaces the addressed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 16 | One-cycle event pulses, one per source |
| master_en | input | 1 | Global interrupt enable from the CPU |
| instr_ret | input | 1 | Strobe: one instruction retired |
| ack_valid | input | 1 | CPU accepts an interrupt this cycle |
| ack_idx | input | 4 | Index of the accepted source |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 (with bus_en) |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 2 | Bit 1 register select, bit 0 byte select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register/byte |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 4 | Index of the selected pending source |

## Verification
The bench aims at the same-cycle collisions. One is an event colliding with an acknowledge of the same flag: a design that lets the clear win would lose that interrupt. The other is an event arriving during a zero write: a design that treats the write as a store would drop it. It also checks that a software-set flag lower in index than the current winner is not presented before a retire strobe, since a design without the hold would switch `irq_idx` one cycle early. Byte writes to the high half carrying ones in the reserved positions, and events on those positions, show whether masked bits ever read back nonzero. Reads of both byte lanes and of the enable register show whether a byte write disturbed the other half.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the interrupt flag bank.
// Assumes the data width is a whole number of bytes.
package irq_flag_pkg;
    localparam int BYTE_W = 8;

    // Register selected by the upper address bit.
    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_EN   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_flag_cell.sv
`timescale 1ns/1ps
// One interrupt source: request flag, enable bit and software hold bit.
// When IMPL is 0 the position is absent: all outputs are tied to 0.
// Assumes every strobe is qualified by the caller (bus decode, ack decode).
module irq_flag_cell #(
    parameter bit IMPL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic sw_set,
    input  logic ack_clr,
    input  logic retire,
    input  logic en_wr,
    input  logic en_val,
    output logic flag_o,
    output logic en_o,
    output logic hold_o
);
    if (IMPL) begin : g_impl
        logic flag_q, en_q, hold_q, flag_d;

        // Next flag value: an event or a software set beats an acknowledge.
        always_comb begin
            flag_d = evt | sw_set | (flag_q & ~ack_clr);
        end

        // Flag, enable and hold registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                en_q   <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                flag_q <= flag_d;
                if (en_wr) en_q <= en_val;
                hold_q <= (sw_set | (hold_q & ~retire)) & flag_d;
            end
        end

        assign flag_o = flag_q;
        assign en_o   = en_q;
        assign hold_o = hold_q;
    end else begin : g_absent
        logic unused_in;
        assign unused_in = ^{clk, rst_n, evt, sw_set, ack_clr, retire, en_wr, en_val};
        assign flag_o = 1'b0;
        assign en_o   = 1'b0;
        assign hold_o = 1'b0;
    end
endmodule

// File: rtl/irq_bus_lane.sv
`timescale 1ns/1ps
// Bus decode for the flag and enable registers.
// Turns a word or byte write into per-bit write strobes and aligned values,
// and muxes the addressed register or byte onto the read data.
// Byte data always travels on the low byte of the bus.
module irq_bus_lane
    import irq_flag_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LANE_AW = 1,
    parameter int ADDR_W  = LANE_AW + 1
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] flag_q,
    input  logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] flag_wr_bits,
    output logic [DATA_W-1:0] en_wr_bits,
    output logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int LANES = DATA_W / BYTE_W;

    reg_sel_e            sel;
    logic [LANE_AW-1:0]  lane;
    logic [DATA_W-1:0]   lane_bits;
    logic                wr;

    assign sel  = reg_sel_e'(bus_addr[ADDR_W-1]);
    assign lane = bus_addr[LANE_AW-1:0];
    assign wr   = bus_en & bus_we;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic hit;
        assign hit = bus_word | (lane == LANE_AW'(l));
        assign lane_bits[l*BYTE_W +: BYTE_W] = {BYTE_W{hit}};
        assign wr_val[l*BYTE_W +: BYTE_W] =
            bus_word ? bus_wdata[l*BYTE_W +: BYTE_W] : bus_wdata[BYTE_W-1:0];
    end

    assign flag_wr_bits = (wr && sel == SEL_FLAG) ? lane_bits : '0;
    assign en_wr_bits   = (wr && sel == SEL_EN)   ? lane_bits : '0;

    // Read mux: full register for a word, one zero-extended byte otherwise.
    always_comb begin
        logic [DATA_W-1:0] src;
        src = (sel == SEL_EN) ? en_q : flag_q;
        if (bus_word) bus_rdata = src;
        else          bus_rdata = DATA_W'(src[lane*BYTE_W +: BYTE_W]);
    end
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
// Lowest-index-first priority encoder over the pending vector.
// Reports index 0 and found=0 when nothing is pending.
module irq_prio_enc #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] pend,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
        found = |pend;
    end
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
// Interrupt request flag bank: latches peripheral events, gates them with
// per-source and master enables, presents the lowest pending index to the
// CPU and clears the acknowledged flag. Word and byte bus access to the
// flag and enable registers. IMPL_MASK marks which positions exist.
module irq_flag_bank #(
    parameter int               DATA_W    = 16,
    parameter logic [DATA_W-1:0] IMPL_MASK = 16'h77FF,
    parameter int               IDX_W     = $clog2(DATA_W),
    parameter int               LANE_AW   = (DATA_W / 8 > 1) ? $clog2(DATA_W / 8) : 1,
    parameter int               ADDR_W    = LANE_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              master_en,
    input  logic              instr_ret,
    input  logic              ack_valid,
    input  logic [IDX_W-1:0]  ack_idx,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_idx
);
    logic [DATA_W-1:0] flag_q, en_q, hold_q;
    logic [DATA_W-1:0] flag_wr_bits, en_wr_bits, wr_val;
    logic [DATA_W-1:0] ack_vec, pend;
    logic              any_pend;

    irq_bus_lane #(
        .DATA_W (DATA_W),
        .LANE_AW(LANE_AW),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_word    (bus_word),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .flag_q      (flag_q),
        .en_q        (en_q),
        .flag_wr_bits(flag_wr_bits),
        .en_wr_bits  (en_wr_bits),
        .wr_val      (wr_val),
        .bus_rdata   (bus_rdata)
    );

    // Decode the acknowledge index into a one-hot clear vector.
    always_comb begin
        ack_vec = '0;
        if (ack_valid) ack_vec[ack_idx] = 1'b1;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_src
        irq_flag_cell #(
            .IMPL(IMPL_MASK[i])
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_i[i]),
            .sw_set (flag_wr_bits[i] & wr_val[i]),
            .ack_clr(ack_vec[i]),
            .retire (instr_ret),
            .en_wr  (en_wr_bits[i]),
            .en_val (wr_val[i]),
            .flag_o (flag_q[i]),
            .en_o   (en_q[i]),
            .hold_o (hold_q[i])
        );
    end

    assign pend = flag_q & en_q & ~hold_q;

    irq_prio_enc #(
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_prio (
        .pend (pend),
        .found(any_pend),
        .idx  (irq_idx)
    );

    assign irq_req = master_en & any_pend;
endmodule

// File: rtl/irq_flag_bank_chk.sv
`timescale 1ns/1ps
// Property checker for irq_flag_bank, attached by bind below.
// Observes ports plus the flag, enable and hold registers.
module irq_flag_bank_chk #(
    parameter int               DATA_W    = 16,
    parameter logic [DATA_W-1:0] IMPL_MASK = 16'h77FF,
    parameter int               IDX_W     = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] evt_i,
    input logic              master_en,
    input logic              ack_valid,
    input logic [IDX_W-1:0]  ack_idx,
    input logic              bus_en,
    input logic              bus_we,
    input logic              irq_req,
    input logic [IDX_W-1:0]  irq_idx,
    input logic [DATA_W-1:0] flag_q,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] hold_q
);
    // R2 and R8: every implemented event is set in the flags one edge later.
    a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i & IMPL_MASK) != '0 |=>
            ((flag_q & $past(evt_i & IMPL_MASK)) == $past(evt_i & IMPL_MASK)));

    // R3: no request without the master enable.
    a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> !irq_req);

    // R4 and R6: the presented source is set, enabled and not held.
    a_r4_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flag_q[irq_idx] && en_q[irq_idx] && !hold_q[irq_idx]));

    // R7: an acknowledge without a colliding event or write clears the flag.
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !evt_i[ack_idx] && !(bus_en && bus_we)) |=>
            !flag_q[$past(ack_idx)]);

    // R9: absent positions never hold a one.
    a_r9_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q | en_q | hold_q) & ~IMPL_MASK) == '0);
endmodule

bind irq_flag_bank irq_flag_bank_chk #(
    .DATA_W   (DATA_W),
    .IMPL_MASK(IMPL_MASK),
    .IDX_W    (IDX_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .master_en(master_en),
    .ack_valid(ack_valid),
    .ack_idx  (ack_idx),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .irq_req  (irq_req),
    .irq_idx  (irq_idx),
    .flag_q   (flag_q),
    .en_q     (en_q),
    .hold_q   (hold_q)
);

// File: tb/irq_flag_bank_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver updates a reference model after each edge and
// queues the expected outputs; the monitor compares them at the falling edge.
module irq_flag_bank_tb_top;
    localparam logic [15:0] MASK = 16'h77FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0;
    logic        master_en = 1'b0;
    logic        instr_ret = 1'b0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_idx = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_req;
    logic [3:0]  irq_idx;

    always #4 clk = ~clk;

    irq_flag_bank dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .master_en(master_en),
        .instr_ret(instr_ret), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .bus_en(bus_en), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_idx(irq_idx)
    );

    typedef struct {
        string       tag;
        logic [15:0] rd;
        logic        req;
        logic [3:0]  idx;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mflag = '0, men = '0, mhold = '0;

    // Monitor: compare queued expectations against the outputs.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (bus_rdata !== e.rd || irq_req !== e.req || irq_idx !== e.idx) begin
                errors++;
                $display("FAIL %s: rdata=%h req=%b idx=%0d expected rdata=%h req=%b idx=%0d",
                         e.tag, bus_rdata, irq_req, irq_idx, e.rd, e.req, e.idx);
            end
        end
    end

    function automatic logic [15:0] model_read(logic [1:0] a, logic w);
        logic [15:0] src;
        src = a[1] ? men : mflag;
        if (w) return src;
        return a[0] ? {8'h00, src[15:8]} : {8'h00, src[7:0]};
    endfunction

    // Push expectation from the model state and current read address.
    task automatic push_exp(string tag);
        exp_t e;
        logic [15:0] p;
        p = mflag & men & ~mhold;
        e.tag = tag;
        e.rd  = model_read(bus_addr, bus_word);
        e.req = master_en & (p != 0);
        e.idx = 4'd0;
        for (int i = 15; i >= 0; i--) if (p[i]) e.idx = 4'(i);
        q.push_back(e);
    endtask

    // Driver: one clock with the given stimulus, then one expectation.
    task automatic cyc(string tag, logic [15:0] ev, logic we, logic [1:0] a,
                       logic w, logic [15:0] wd, logic av, logic [3:0] ai,
                       logic rt, logic mie);
        logic [15:0] bits, val, swset, ackc, nflag;
        evt_i = ev; bus_en = we; bus_we = we; bus_addr = a; bus_word = w;
        bus_wdata = wd; ack_valid = av; ack_idx = ai; instr_ret = rt;
        master_en = mie;
        @(posedge clk);
        bits = w ? 16'hFFFF : (a[0] ? 16'hFF00 : 16'h00FF);
        val  = w ? wd : {wd[7:0], wd[7:0]};
        swset = (we && !a[1]) ? (bits & val & MASK) : 16'h0;
        ackc  = av ? (16'h1 << ai) : 16'h0;
        nflag = (mflag & ~ackc) | (ev & MASK) | swset;
        mhold = (swset | (mhold & (rt ? 16'h0 : 16'hFFFF))) & nflag;
        mflag = nflag;
        if (we && a[1]) men = ((men & ~bits) | (val & bits)) & MASK;
        push_exp(tag);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 rst_n = 1'b1;
        cyc("R1 reset flags", 16'h0, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 0);
        cyc("R1 reset enables", 16'h0, 0, 2'd2, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R2 event with enables off", 16'h0008, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 0);
        cyc("R9 R10 enable word write masked", 16'h0, 1, 2'd2, 1, 16'hFFFF, 0, 4'd0, 0, 0);
        cyc("R3 idx shown with master off", 16'h0, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 0);
        cyc("R3 request with master on", 16'h0, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R4 lowest index wins", 16'h0202, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R7 ack clears only bit 1", 16'h0, 0, 2'd0, 1, 16'h0, 1, 4'd1, 0, 1);
        cyc("R8 event beats ack", 16'h0008, 0, 2'd0, 1, 16'h0, 1, 4'd3, 0, 1);
        cyc("R6 sw set held", 16'h0, 1, 2'd0, 0, 16'h0001, 0, 4'd0, 0, 1);
        cyc("R6 still held without retire", 16'h0, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R6 released after retire", 16'h0, 0, 2'd0, 1, 16'h0, 0, 4'd0, 1, 1);
        cyc("R7 ack bit 0", 16'h0, 0, 2'd0, 1, 16'h0, 1, 4'd0, 0, 1);
        cyc("R9 R10 high byte write", 16'h0, 1, 2'd1, 0, 16'h0098, 0, 4'd0, 0, 1);
        cyc("R9 reserved events ignored", 16'h8800, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R5 zero write keeps flags, event lands", 16'h0020, 1, 2'd0, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R10 low byte read", 16'h0, 0, 2'd0, 0, 16'h0, 0, 4'd0, 1, 1);
        cyc("R10 enable high byte write", 16'h0, 1, 2'd3, 0, 16'h0000, 0, 4'd0, 0, 1);
        cyc("R10 enable low byte kept", 16'h0, 0, 2'd2, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R3 master off drops request", 16'h0, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 0);
        cyc("R10 enable word write", 16'h0, 1, 2'd2, 1, 16'h0004, 0, 4'd0, 0, 1);
        cyc("R3 R2 new event enabled", 16'h0004, 0, 2'd0, 1, 16'h0, 0, 4'd0, 0, 1);
        cyc("R7 ack bit 2 leaves others", 16'h0, 0, 2'd0, 1, 16'h0, 1, 4'd2, 0, 1);
        cyc("R9 word write to reserved bits", 16'h0, 1, 2'd0, 1, 16'h8800, 0, 4'd0, 0, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule